// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Generator

This core supervises a processor. One reset output is asserted for any of three reasons: the chip has just powered up, the supply has fallen out of range, or the watchdog has expired. Every cause is stretched to the same length, counted in ticks of a 1 ms timebase. The reset output comes in two polarities, one active low and one active high, and both are driven from a single internal condition.

The watchdog does not have a dedicated kick pin. The host restarts it by producing a particular pattern on the two-wire bus. First, SDA and SCL must fall together. Then a stop condition must follow, which is SDA rising while SCL is high. If the host sends nothing of this kind within the selected interval, the core pulses reset. When a watchdog reset ends, the count starts again, so a bus that stays stuck produces reset pulses over and over.

A two-bit interval setting picks 200, 600 or 1400 ticks, or turns the watchdog off. The host writes this setting through a small port. A write-protect input can lock the setting. The setting survives every reset that the core itself generates.

Top module: `cpu_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it rises, the reset outputs are asserted and `cfg_q` reads 2'b00. Reset is released only after 250 timebase ticks during which the supply has been good.
- R2: When `vlow` is high or `pwr_good` is low, the reset outputs are asserted from the next clock, and they stay asserted while that condition lasts.
- R3: Release happens exactly on the 250th tick counted after the supply fault clears. A new fault during the stretch starts the count over.
- R4: The interval codes are 2'b00 for 200 ticks, 2'b01 for 600 ticks and 2'b10 for 1400 ticks. Code 2'b11 disables the watchdog. With the watchdog enabled, reset is asserted on the tick that reaches the selected interval if no kick has occurred.
- R5: A kick happens when SDA and SCL fall in the same sampled cycle, followed by a stop (SDA rises while SCL stays high). A kick clears the watchdog count. Both bus lines pass through two-flop synchronizers first.
- R6: A start condition (SDA falls while SCL stays high) after the two lines fall together cancels the armed kick. A stop that has not been armed does not kick.
- R7: A write with `cfg_we` high loads `cfg_wdata` into the setting when `wp` is low. When `wp` is high, the write is ignored and `cfg_q` does not change.
- R8: The setting keeps its value through supply resets and watchdog resets. Only `rst_n` restores 2'b00.
- R9: `rst_out_n` is always the inverse of `rst_out`.
- R10: A watchdog expiry gives a reset pulse of 250 ticks. The count is held at zero while reset is asserted and restarts from zero at release.
- R11: If a kick and an expiry land on the same clock, the kick wins and no reset is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the core |
| tick_1ms | input | 1 | One-cycle timebase pulse |
| vlow | input | 1 | Synchronized low-supply flag, high means below trip |
| pwr_good | input | 1 | Supply reported stable |
| sda | input | 1 | Bus data line |
| scl | input | 1 | Bus clock line |
| wp | input | 1 | Write protect for the interval setting |
| cfg_we | input | 1 | Setting write strobe |
| cfg_wdata | input | 2 | New interval code |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |
| cfg_q | output | 2 | Stored interval code |

## Verification
The kick path and the expiry path can both act on the same clock edge. The bench provokes this collision with a sweep. Each attempt arms a kick and then places the stop condition one cycle later than the attempt before. The sweep covers more than a full tick period around the moment the count expires, so at least one stop reaches the counter on exactly the expiring tick. The behavioural model decides each case on its own and counts how many collisions occur. The bench requires at least one collision, and the outputs must show that the kick won on every colliding clock.

// File: rtl/sup_pkg.sv
// Package: types shared by the supervisor blocks.
package sup_pkg;
    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } kick_st_t;
endpackage

// File: rtl/sup_sync.sv
// Two-flop synchronizer bank.
// Assumes the lines are idle-high bus lines, so every stage resets to 1.
module sup_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        // Two register stages per bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= 1'b1;
                q[i] <= 1'b1;
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/sup_kick_det.sv
// Detects the bus kick pattern. SDA and SCL must fall in the same cycle,
// which arms the detector. A later stop (SDA rises, SCL high) produces a
// one-cycle kick pulse. A start seen while armed disarms the detector.
// Assumes both inputs are already synchronized.
module sup_kick_det
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic kick
);
    logic     sda_d, scl_d;
    kick_st_t st, st_nx;
    logic     pair_fall, stop_c, start_c;

    // Hold the previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s;
            scl_d <= scl_s;
        end
    end

    // Decode the bus events.
    always_comb begin
        pair_fall = sda_d && !sda_s && scl_d && !scl_s;
        stop_c    = !sda_d && sda_s && scl_d && scl_s;
        start_c   = sda_d && !sda_s && scl_d && scl_s;
    end

    // Next state of the arm/disarm machine.
    always_comb begin
        st_nx = st;
        case (st)
            KS_IDLE:  if (pair_fall) st_nx = KS_ARMED;
            KS_ARMED: if (stop_c || start_c) st_nx = KS_IDLE;
            default:  st_nx = KS_IDLE;
        endcase
    end

    // State register and registered kick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= KS_IDLE;
            kick <= 1'b0;
        end else begin
            st   <= st_nx;
            kick <= (st == KS_ARMED) && stop_c;
        end
    end
endmodule

// File: rtl/sup_wdog.sv
// Watchdog counter. It counts timebase ticks up to the selected limit.
// It is cleared by a kick, and held at zero while disabled or while reset
// is out. A kick on the expiring tick wins over the expiry.
module sup_wdog
    import sup_pkg::*;
#(
    parameter int T0 = 200,
    parameter int T1 = 600,
    parameter int T2 = 1400,
    parameter int WW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  wd_sel_t       sel,
    input  logic          hold,
    input  logic          kick,
    output logic          fire,
    output logic [WW-1:0] cnt
);
    localparam logic [WW-1:0] L0 = WW'(T0 - 1);
    localparam logic [WW-1:0] L1 = WW'(T1 - 1);
    localparam logic [WW-1:0] L2 = WW'(T2 - 1);

    logic [WW-1:0] lim_m1;
    logic          en;

    // Pick the limit for the current code.
    always_comb begin
        case (sel)
            WD_SHORT: lim_m1 = L0;
            WD_MID:   lim_m1 = L1;
            default:  lim_m1 = L2;
        endcase
        en   = (sel != WD_OFF);
        fire = en && tick && !hold && !kick && (cnt >= lim_m1);
    end

    // Tick counter with clear and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (hold || !en || kick) cnt <= '0;
        else if (tick)               cnt <= fire ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sup_stretch.sv
// Reset stretcher. Reset is asserted while a supply fault is present or when
// a watchdog trigger arrives. It is released after STRETCH ticks with no fault.
// Assumes tick is a one-cycle pulse.
module sup_stretch #(
    parameter int STRETCH = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault,
    input  logic trig,
    output logic active
);
    localparam int SW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [SW-1:0] LAST = SW'(STRETCH - 1);

    logic [SW-1:0] cnt;

    // Assert on fault or trigger, count ticks down to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (fault || trig) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_supervisor.sv
// Top of the supervisor. Joins the bus synchronizer, the kick detector,
// the watchdog and the reset stretcher, and holds the interval setting.
// Assumes vlow is already synchronous to clk.
module cpu_supervisor
    import sup_pkg::*;
#(
    parameter int         STRETCH_TICKS = 250,
    parameter int         WD_T0         = 200,
    parameter int         WD_T1         = 600,
    parameter int         WD_T2         = 1400,
    parameter logic [1:0] INIT_CODE     = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       vlow,
    input  logic       pwr_good,
    input  logic       sda,
    input  logic       scl,
    input  logic       wp,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic       rst_out_n,
    output logic       rst_out,
    output logic [1:0] cfg_q
);
    localparam int WW = $clog2(WD_T2 + 1);

    logic [1:0]    bus_s;
    logic          kick_q, wd_fire, fault, active;
    logic [WW-1:0] wd_cnt;
    wd_sel_t       sel_q;

    sup_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sda, scl}), .q(bus_s)
    );

    sup_kick_det u_kick (
        .clk(clk), .rst_n(rst_n), .sda_s(bus_s[1]), .scl_s(bus_s[0]),
        .kick(kick_q)
    );

    // Interval setting: only rst_n clears it, and wp blocks writes.
    always_ff @(posedge clk) begin
        if (!rst_n)             sel_q <= wd_sel_t'(INIT_CODE);
        else if (cfg_we && !wp) sel_q <= wd_sel_t'(cfg_wdata);
    end

    // Supply fault is either comparator flag.
    always_comb fault = vlow || !pwr_good;

    sup_wdog #(.T0(WD_T0), .T1(WD_T1), .T2(WD_T2), .WW(WW)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .sel(sel_q),
        .hold(active), .kick(kick_q), .fire(wd_fire), .cnt(wd_cnt)
    );

    sup_stretch #(.STRETCH(STRETCH_TICKS)) u_str (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .fault(fault),
        .trig(wd_fire), .active(active)
    );

    // Both reset polarities come from one condition.
    always_comb begin
        rst_out   = active;
        rst_out_n = !active;
        cfg_q     = sel_q;
    end
endmodule

// File: rtl/sup_checker.sv
// Checker for cpu_supervisor. It is bound into the top and observes ports
// and internal wires that separate blocks drive.
module sup_checker #(
    parameter int WW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vlow,
    input logic          pwr_good,
    input logic          cfg_we,
    input logic          wp,
    input logic [1:0]    cfg_q,
    input logic          rst_out,
    input logic          rst_out_n,
    input logic          kick,
    input logic [WW-1:0] wd_cnt
);
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out != rst_out_n);

    a_r2_fault_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        (vlow || !pwr_good) |=> rst_out);

    a_r7_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wp) |=> $stable(cfg_q));

    a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (wd_cnt == '0));

    a_r10_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out && $past(rst_out)) |-> (wd_cnt == '0));

    a_r3_no_release_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> $past(!vlow && pwr_good));
endmodule

bind cpu_supervisor sup_checker #(.WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .pwr_good(pwr_good),
    .cfg_we(cfg_we), .wp(wp), .cfg_q(cfg_q), .rst_out(rst_out),
    .rst_out_n(rst_out_n), .kick(kick_q), .wd_cnt(wd_cnt)
);

// File: tb/cpu_supervisor_bench.sv
// Bench: a behavioural reference model, compared with the outputs every clock.
module cpu_supervisor_bench;
    logic clk = 1'b0, rst_n = 1'b0, tick_1ms = 1'b0, vlow = 1'b0, pwr_good = 1'b0;
    logic sda = 1'b1, scl = 1'b1, wp = 1'b0, cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic rst_out_n, rst_out;
    logic [1:0] cfg_q;

    int compared = 0, mismatched = 0, coinc = 0;
    string cur_req = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    cpu_supervisor u_cpu_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .vlow(vlow),
        .pwr_good(pwr_good), .sda(sda), .scl(scl), .wp(wp), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .rst_out_n(rst_out_n), .rst_out(rst_out),
        .cfg_q(cfg_q)
    );

    // Reference model state.
    bit [2:0] sda_h = 3'b111, scl_h = 3'b111;
    bit m_armed = 0, m_kick = 0, m_active = 1;
    int m_cnt = 0, m_wd = 0;
    bit [1:0] m_code = 2'b00;

    function automatic int limit(bit [1:0] c);
        case (c)
            2'b00: return 200;
            2'b01: return 600;
            default: return 1400;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Model update at each edge, then compare the outputs a little later.
    always @(posedge clk) begin
        bit s2, sp, c2, cp, stop_e, start_e, pair_e, en, fire, nk, na, flt;
        if (!rst_n) begin
            sda_h = 3'b111; scl_h = 3'b111; m_armed = 0; m_kick = 0;
            m_active = 1; m_cnt = 0; m_wd = 0; m_code = 2'b00;
        end else begin
            s2 = sda_h[1]; sp = sda_h[2]; c2 = scl_h[1]; cp = scl_h[2];
            stop_e  = !sp && s2 && cp && c2;
            start_e = sp && !s2 && cp && c2;
            pair_e  = sp && !s2 && cp && !c2;
            nk = m_armed && stop_e;
            na = m_armed ? !(stop_e || start_e) : pair_e;
            en = (m_code != 2'b11);
            flt = vlow || !pwr_good;
            fire = en && tick_1ms && !m_active && !m_kick && (m_wd >= limit(m_code) - 1);
            if (en && tick_1ms && !m_active && m_kick && (m_wd >= limit(m_code) - 1)) coinc++;
            if (m_active || !en || m_kick) m_wd = 0;
            else if (tick_1ms) m_wd = fire ? 0 : m_wd + 1;
            if (flt || fire) begin m_active = 1; m_cnt = 0; end
            else if (m_active && tick_1ms) begin
                if (m_cnt == 249) begin m_active = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if (cfg_we && !wp) m_code = cfg_wdata;
            m_kick = nk; m_armed = na;
            sda_h = {sda_h[1:0], sda}; scl_h = {scl_h[1:0], scl};
        end
        #2;
        compared++;
        if (rst_out !== m_active || rst_out_n !== !m_active || cfg_q !== m_code) begin
            mismatched++;
            $display("FAIL %s (R9 polarity) rst=%b/%b cfg=%b exp rst=%b cfg=%b",
                     cur_req, rst_out, rst_out_n, cfg_q, m_active, m_code);
        end
    end

    // Timebase: one tick every fourth cycle.
    initial forever begin
        repeat (3) @(negedge clk);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask

    task automatic arm_only();
        sda = 0; scl = 0; cyc(3);
        scl = 1; cyc(3);
    endtask

    task automatic kick_full();
        arm_only();
        sda = 1; cyc(3);
    endtask

    task automatic wr(bit [1:0] v);
        cfg_wdata = v; cfg_we = 1; cyc(1); cfg_we = 0; cyc(1);
    endtask

    task automatic wait_release(); while (m_active) cyc(1); endtask

    initial begin
        cyc(5);
        chk("R1 reset asserted", rst_out, 1);
        chk("R9 low polarity", rst_out_n, 0);
        chk("R1 init code", cfg_q, 0);
        rst_n = 1; cyc(20); pwr_good = 1;
        cyc(960); chk("R1 still stretched", rst_out, 1);
        cyc(80);  chk("R1 released", rst_out, 0);

        cur_req = "R5";
        for (int i = 0; i < 4; i++) begin kick_full(); cyc(500); end
        chk("R5 kicks keep released", rst_out, 0);

        cur_req = "R4";
        cyc(330); chk("R4 200-tick expiry", rst_out, 1);
        cur_req = "R10";
        cyc(1010); chk("R10 pulse ends", rst_out, 0);
        cyc(830);  chk("R10 repeats", rst_out, 1);

        cur_req = "R7";
        wp = 1; wr(2'b01); chk("R7 wp blocks write", cfg_q, 0);
        wp = 0; wr(2'b01); chk("R7 write accepted", cfg_q, 1);
        cur_req = "R2";
        vlow = 1; cyc(10);
        chk("R2 low supply asserts", rst_out, 1);
        chk("R8 code kept through reset", cfg_q, 1);
        vlow = 0; cyc(400);
        cur_req = "R3";
        vlow = 1; cyc(3); vlow = 0;
        wait_release();

        cur_req = "R4";
        wr(2'b11); cyc(6000); chk("R4 disabled no reset", rst_out, 0);
        wr(2'b10); cyc(5560); chk("R4 1400 not yet", rst_out, 0);
        cyc(80); chk("R4 1400-tick expiry", rst_out, 1);

        cur_req = "R6";
        wr(2'b00); wait_release();
        kick_full(); cyc(300);
        sda = 0; scl = 0; cyc(3); sda = 1; cyc(3); scl = 1; cyc(3);
        sda = 0; cyc(3); sda = 1; cyc(3);
        cyc(515); chk("R6 cancelled kick expires", rst_out, 1);

        cur_req = "R11";
        for (int off = 0; off < 17; off++) begin
            wait_release();
            kick_full(); arm_only();
            cyc(788 + off); sda = 1; cyc(4);
        end
        cyc(20);
        chk("R11 collision exercised", (coinc > 0) ? 1 : 0, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired in %s act=hung exp=done", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule